// File: doc/BRIEF.md
# Serial OSD Command Decoder

This block sits between a host's three-wire serial link and an on-screen display character engine. The host frames a transfer by pulling an active-low enable low, then clocks 8-bit words in MSB first on the rising edge of the serial clock. Each word is either an identification word (bit 7 set) that chooses a command, or a data word (bit 7 clear) that feeds the command chosen last. The chosen command stays in force across words, so a host can repeat data words without resending the identification word. All three serial pins are sampled into the system clock domain through synchronizer stages. The serial clock must be slow compared with the system clock.

An address-setup command loads a row and column pointer into a 12-row by 24-column character store. After the character-write identification word (0x90), the decoder locks. Every later word of the transfer, whatever its bit 7, becomes one character cell: bit 7 is an attribute flag and bits 6..0 are the character code. The cell is written at the pointer, and the pointer then advances. Releasing the enable returns the decoder to address setup. The remaining identification codes load configuration registers for position, size, display control, sync detection and four extended settings. One display-control bit starts a fill of the whole store with the blank code 0x7F.

Writes leave on a valid/ready port. A write stays presented, with its row, column and data held, until `wr_ready` is seen high. Only one character write can be outstanding. A character word that completes while the previous write is still outstanding, or while a fill is running, is dropped. In that case the pointer does not advance. The host is expected to pace its words so that this does not happen.

Top module: `osd_cmd_decoder`

## Requirements
- R1: After reset no write is presented, every configuration field reads 0, the pointer is row 0 / column 0, and the decoder is in address-setup mode.
- R2: Bits are taken only while `ser_en_n` is low, MSB first on `ser_clk` rising edges. Clock edges while the enable is high have no effect, and a partial word is discarded when the enable rises.
- R3: An identification word with bits 7..4 = 1010, 1011, 1100, 1101 or 1110 selects configuration slot 0, 1, 2, 3 or 4. Bits 7..4 = 1111 select slot 5 + bits 3..2. The word's bits 3..0 go into slot bits 10..7. Each later data word writes its bits 6..0 into slot bits 6..0. Slot k occupies `cfg_bus[11k+10 : 11k]`.
- R4: The selected command persists over any number of data words until another identification word arrives. Repeated data words overwrite the same slot.
- R5: Identification word 1000 rrrr sets the row to rrrr, clamped to 11. A data word in address-setup mode sets the column to bits 4..0, clamped to 23.
- R6: After word 0x90, every word up to enable release, including words with bit 7 set, is written unchanged as cell data at the pointer. No configuration slot changes.
- R7: After each accepted character write the column advances by one. Column 23 wraps to column 0 of the next row, and row 11 column 23 wraps to row 0 column 0.
- R8: Raising the enable clears the character-write lock and selects address-setup mode. The pointer keeps its value.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_row`, `wr_col` and `wr_data` hold steady. A character word completing while a write is outstanding is dropped without advancing the pointer.
- R10: An identification word 1100 x1xx starts a fill that writes 0x7F exactly once to each of the 288 cells, row by row. Character words completing during the fill are dropped.
- R11: An identification word 1001 with nonzero bits 3..0 does not lock. Data words following it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Serial transfer enable, active low |
| ser_clk | input | 1 | Serial bit clock, idles low, data taken on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| wr_valid | output | 1 | Character store write presented |
| wr_ready | input | 1 | Character store accepts the write this cycle |
| wr_row | output | 4 | Write row, 0 to 11 |
| wr_col | output | 5 | Write column, 0 to 23 |
| wr_data | output | 8 | Attribute flag (bit 7) and character code (bits 6..0) |
| cfg_bus | output | 99 | Nine 11-bit configuration slots, slot k at bits 11k+10..11k |

## Verification
A wrong mode register shows up at the next completed word. Either a configuration slot changes when it should not, or a character lands in a cell that should have stayed untouched, or an expected write is missing. So a mode fault is visible within one serial word, about a hundred system cycles at the bench's pacing. A pointer fault appears as data in the wrong cell at the next accepted write. The wrap and clamp corners are driven directly to expose off-by-one errors at column 23 and row 11. Faults in the fill sequencer show as a write count other than 288, or as a cell left with anything but 0x7F. Either is visible as soon as the fill ends.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ADDR = 2'd0,
    MODE_CHAR = 2'd1,
    MODE_CFG  = 2'd2,
    MODE_IDLE = 2'd3
  } mode_e;

  localparam int BYTE_W    = 8;
  localparam int ROW_FLD_W = 4;
  localparam int COL_FLD_W = 5;
  localparam int CFG_N     = 9;
  localparam int CFG_W     = 11;
  localparam int CFG_IW    = $clog2(CFG_N);
  localparam int EXT_BASE  = 5;

  localparam logic [3:0] ID_ADDR  = 4'h8;
  localparam logic [3:0] ID_CHAR  = 4'h9;
  localparam logic [3:0] ID_CFG0  = 4'hA;
  localparam logic [3:0] ID_DISP  = 4'hC;
  localparam logic [3:0] ID_EXT   = 4'hF;
  localparam int         FILL_BIT = 2;

  function automatic logic [CFG_IW-1:0] cfg_slot(input logic [3:0] hi, input logic [3:0] lo);
    if (hi == ID_EXT) return CFG_IW'(EXT_BASE) + CFG_IW'(lo[3:2]);
    else              return CFG_IW'(hi - ID_CFG0);
  endfunction
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
  import osd_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              en_act,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] en_sr, ck_sr, dt_sr;
  logic                   ck_d;
  logic [BYTE_W-2:0]      shift_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sr <= '1;
      ck_sr <= '0;
      dt_sr <= '0;
      ck_d  <= 1'b0;
    end else begin
      en_sr <= {en_sr[SYNC_STAGES-2:0], ser_en_n};
      ck_sr <= {ck_sr[SYNC_STAGES-2:0], ser_clk};
      dt_sr <= {dt_sr[SYNC_STAGES-2:0], ser_dat};
      ck_d  <= ck_sr[SYNC_STAGES-1];
    end
  end

  assign en_act = ~en_sr[SYNC_STAGES-1];
  assign rise   = ck_sr[SYNC_STAGES-1] & ~ck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shift_q  <= '0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else if (!en_act) begin
      cnt_q    <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        shift_q <= {shift_q[BYTE_W-3:0], dt_sr[SYNC_STAGES-1]};
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          byte_q   <= {shift_q, dt_sr[SYNC_STAGES-1]};
          byte_vld <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_act,
  input  logic                   byte_vld,
  input  logic [BYTE_W-1:0]      byte_q,
  output logic                   set_row,
  output logic [ROW_FLD_W-1:0]   row_in,
  output logic                   set_col,
  output logic [COL_FLD_W-1:0]   col_in,
  output logic                   char_req,
  output logic [BYTE_W-1:0]      char_data,
  output logic                   fill_req,
  output logic [CFG_N*CFG_W-1:0] cfg_bus
);
  mode_e             mode_q;
  logic [CFG_IW-1:0] slot_q;
  logic [CFG_W-1:0]  cfg_q [CFG_N];
  logic              vld, is_id;
  logic [3:0]        hi, lo;

  assign vld       = byte_vld & en_act;
  assign hi        = byte_q[7:4];
  assign lo        = byte_q[3:0];
  assign is_id     = byte_q[7] & (mode_q != MODE_CHAR);
  assign row_in    = lo;
  assign col_in    = byte_q[COL_FLD_W-1:0];
  assign char_data = byte_q;

  always_comb begin
    set_row  = 1'b0;
    set_col  = 1'b0;
    char_req = 1'b0;
    fill_req = 1'b0;
    if (vld) begin
      if (mode_q == MODE_CHAR) begin
        char_req = 1'b1;
      end else if (is_id) begin
        set_row  = (hi == ID_ADDR);
        fill_req = (hi == ID_DISP) & lo[FILL_BIT];
      end else begin
        set_col  = (mode_q == MODE_ADDR);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ADDR;
      slot_q <= '0;
      for (int i = 0; i < CFG_N; i++) cfg_q[i] <= '0;
    end else if (!en_act) begin
      mode_q <= MODE_ADDR;
    end else if (vld) begin
      if (is_id) begin
        if (hi == ID_ADDR) begin
          mode_q <= MODE_ADDR;
        end else if (hi == ID_CHAR) begin
          mode_q <= (lo == 4'h0) ? MODE_CHAR : MODE_IDLE;
        end else if (hi >= ID_CFG0) begin
          mode_q                            <= MODE_CFG;
          slot_q                            <= cfg_slot(hi, lo);
          cfg_q[cfg_slot(hi, lo)][CFG_W-1:7] <= lo;
        end else begin
          mode_q <= MODE_IDLE;
        end
      end else if (mode_q == MODE_CFG) begin
        cfg_q[slot_q][6:0] <= byte_q[6:0];
      end
    end
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    assign cfg_bus[g*CFG_W +: CFG_W] = cfg_q[g];
  end
endmodule

// File: rtl/osd_addr_ctr.sv
module osd_addr_ctr
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_row,
  input  logic [ROW_FLD_W-1:0] row_in,
  input  logic                 set_col,
  input  logic [COL_FLD_W-1:0] col_in,
  input  logic                 step,
  output logic [RW-1:0]        row,
  output logic [CW-1:0]        col
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else begin
      if (set_row) row <= (int'(row_in) > ROWS-1) ? ROW_LAST : RW'(row_in);
      if (set_col) col <= (int'(col_in) > COLS-1) ? COL_LAST : CW'(col_in);
      if (step) begin
        if (col == COL_LAST) begin
          col <= '0;
          row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_wr_port.sv
module osd_wr_port #(
  parameter int          ROWS = 12,
  parameter int          COLS = 24,
  parameter int          DW   = 8,
  parameter logic [DW-1:0] FILL = 8'h7F,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_req,
  input  logic [RW-1:0] char_row,
  input  logic [CW-1:0] char_col,
  input  logic [DW-1:0] char_data,
  input  logic          fill_req,
  output logic          char_ok,
  output logic          char_pend,
  output logic          fill_busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [RW-1:0] wr_row,
  output logic [CW-1:0] wr_col,
  output logic [DW-1:0] wr_data
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS-1);

  logic [RW-1:0] p_row, f_row;
  logic [CW-1:0] p_col, f_col;
  logic [DW-1:0] p_data;
  logic          fill_go;

  assign char_ok  = ~fill_busy & ~char_pend;
  assign wr_valid = char_pend | fill_busy;
  assign wr_row   = char_pend ? p_row  : f_row;
  assign wr_col   = char_pend ? p_col  : f_col;
  assign wr_data  = char_pend ? p_data : FILL;
  assign fill_go  = fill_busy & ~char_pend & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_pend <= 1'b0;
      p_row     <= '0;
      p_col     <= '0;
      p_data    <= '0;
    end else if (char_pend) begin
      if (wr_ready) char_pend <= 1'b0;
    end else if (char_req && char_ok) begin
      char_pend <= 1'b1;
      p_row     <= char_row;
      p_col     <= char_col;
      p_data    <= char_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_busy <= 1'b0;
      f_row     <= '0;
      f_col     <= '0;
    end else if (!fill_busy) begin
      if (fill_req) begin
        fill_busy <= 1'b1;
        f_row     <= '0;
        f_col     <= '0;
      end
    end else if (fill_go) begin
      if (f_col == COL_LAST) begin
        f_col <= '0;
        if (f_row == ROW_LAST) fill_busy <= 1'b0;
        else                   f_row     <= f_row + 1'b1;
      end else begin
        f_col <= f_col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int              ROWS        = 12,
  parameter int              COLS        = 24,
  parameter int              SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] FILL      = 8'h7F,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_en_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [RW-1:0]          wr_row,
  output logic [CW-1:0]          wr_col,
  output logic [BYTE_W-1:0]      wr_data,
  output logic [CFG_N*CFG_W-1:0] cfg_bus
);
  logic                 en_act, byte_vld;
  logic [BYTE_W-1:0]    byte_q;
  logic                 set_row, set_col, char_req, fill_req;
  logic [ROW_FLD_W-1:0] row_in;
  logic [COL_FLD_W-1:0] col_in;
  logic [BYTE_W-1:0]    char_data;
  logic [RW-1:0]        cur_row;
  logic [CW-1:0]        cur_col;
  logic                 char_ok, char_pend, fill_busy;

  osd_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .en_act(en_act), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  osd_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_act(en_act), .byte_vld(byte_vld),
    .byte_q(byte_q), .set_row(set_row), .row_in(row_in), .set_col(set_col),
    .col_in(col_in), .char_req(char_req), .char_data(char_data),
    .fill_req(fill_req), .cfg_bus(cfg_bus)
  );

  osd_addr_ctr #(.ROWS(ROWS), .COLS(COLS)) u_addr (
    .clk(clk), .rst_n(rst_n), .set_row(set_row), .row_in(row_in),
    .set_col(set_col), .col_in(col_in), .step(char_req & char_ok),
    .row(cur_row), .col(cur_col)
  );

  osd_wr_port #(.ROWS(ROWS), .COLS(COLS), .DW(BYTE_W), .FILL(FILL)) u_wr (
    .clk(clk), .rst_n(rst_n), .char_req(char_req), .char_row(cur_row),
    .char_col(cur_col), .char_data(char_data), .fill_req(fill_req),
    .char_ok(char_ok), .char_pend(char_pend), .fill_busy(fill_busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data)
  );
endmodule

// File: rtl/osd_cmd_checks.sv
module osd_cmd_checks
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  parameter logic [BYTE_W-1:0] FILL = 8'h7F,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [RW-1:0]          wr_row,
  input logic [CW-1:0]          wr_col,
  input logic [BYTE_W-1:0]      wr_data,
  input logic                   byte_vld,
  input logic                   char_pend,
  input logic                   fill_busy,
  input logic [CFG_N*CFG_W-1:0] cfg_bus
);
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> int'(wr_row) <= ROWS-1); // R5
  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> int'(wr_col) <= COLS-1); // R7
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_row) && $stable(wr_col) && $stable(wr_data))); // R9
  AST_CFG_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cfg_bus)); // R3
  AST_FILL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && fill_busy && !char_pend) |-> wr_data == FILL); // R10
endmodule

bind osd_cmd_decoder osd_cmd_checks #(.ROWS(ROWS), .COLS(COLS), .FILL(FILL)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .byte_vld(byte_vld),
  .char_pend(char_pend), .fill_busy(fill_busy), .cfg_bus(cfg_bus)
);

// File: tb/test_osd_cmd_decoder.sv
module test_osd_cmd_decoder;
  localparam int ROWS = 12;
  localparam int COLS = 24;
  localparam int CELLS = ROWS * COLS;
  localparam int PH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        wr_ready = 1'b1;
  logic        wr_valid;
  logic [3:0]  wr_row;
  logic [4:0]  wr_col;
  logic [7:0]  wr_data;
  logic [98:0] cfg_bus;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  logic [7:0] mem [CELLS];

  always #5 clk = ~clk;

  osd_cmd_decoder i_osd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .cfg_bus(cfg_bus)
  );

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      mem[int'(wr_row) * COLS + int'(wr_col)] = wr_data;
      wr_count++;
    end
  end

  function automatic int slot(input int k);
    return int'(cfg_bus[k*11 +: 11]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_xfer();
    ser_en_n = 1'b0;
    wait_cyc(PH);
  endtask

  task automatic close_xfer();
    wait_cyc(PH);
    ser_en_n = 1'b1;
    wait_cyc(12);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      ser_dat = b[i];
      wait_cyc(PH);
      ser_clk = 1'b1;
      wait_cyc(PH);
      ser_clk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < CELLS; i++) mem[i] = 8'h00;
  endtask

  task automatic t_reset();
    check("R1 wr_valid", int'(wr_valid), 0);
    check("R1 cfg_bus", int'(cfg_bus == '0), 1);
    open_xfer(); send_byte(8'h90); send_byte(8'h01); close_xfer();
    check("R1 pointer origin", int'(mem[0]), 8'h01);
    check("R1 write count", wr_count, 1);
  endtask

  task automatic t_char_lock();
    int c0 = wr_count;
    open_xfer();
    send_byte(8'h83); send_byte(8'h05); send_byte(8'h90);
    send_byte(8'h41); send_byte(8'hC2); send_byte(8'hA5);
    close_xfer();
    check("R5 row3 col5", int'(mem[3*COLS+5]), 8'h41);
    check("R6 bit7 word as data", int'(mem[3*COLS+6]), 8'hC2);
    check("R6 id-like word as data", int'(mem[3*COLS+7]), 8'hA5);
    check("R6 slot0 untouched", slot(0), 0);
    check("R7 count", wr_count - c0, 3);
  endtask

  task automatic t_wrap();
    open_xfer();
    send_byte(8'h82); send_byte(8'h17); send_byte(8'h90);
    send_byte(8'h33); send_byte(8'h34);
    close_xfer();
    check("R7 col23", int'(mem[2*COLS+23]), 8'h33);
    check("R7 next row", int'(mem[3*COLS]), 8'h34);
    open_xfer();
    send_byte(8'h8B); send_byte(8'h17); send_byte(8'h90);
    send_byte(8'h11); send_byte(8'h22);
    close_xfer();
    check("R7 last cell", int'(mem[CELLS-1]), 8'h11);
    check("R7 wrap to origin", int'(mem[0]), 8'h22);
  endtask

  task automatic t_clamp();
    open_xfer();
    send_byte(8'h8F); send_byte(8'h1F); send_byte(8'h90); send_byte(8'h55);
    close_xfer();
    check("R5 clamp row11 col23", int'(mem[CELLS-1]), 8'h55);
  endtask

  task automatic t_release();
    open_xfer();
    send_byte(8'h84); send_byte(8'h02); send_byte(8'h90); send_byte(8'h10);
    close_xfer();
    open_xfer();
    send_byte(8'h07); send_byte(8'h90); send_byte(8'h61);
    close_xfer();
    check("R8 first", int'(mem[4*COLS+2]), 8'h10);
    check("R8 addr mode and row kept", int'(mem[4*COLS+7]), 8'h61);
    check("R8 no write at col3", int'(mem[4*COLS+3]), 8'h00);
  endtask

  task automatic t_cfg();
    open_xfer();
    send_byte(8'hA3); send_byte(8'h12); send_byte(8'h2A);
    send_byte(8'hB5); send_byte(8'h44);
    send_byte(8'hF6); send_byte(8'h01);
    send_byte(8'hFD); send_byte(8'h7F);
    send_byte(8'hE1); send_byte(8'h00);
    send_byte(8'hD2); send_byte(8'h05); send_byte(8'h06);
    close_xfer();
    check("R4 slot0 last data", slot(0), (3 << 7) | 8'h2A);
    check("R3 slot1", slot(1), (5 << 7) | 8'h44);
    check("R3 ext slot6", slot(6), (6 << 7) | 8'h01);
    check("R3 ext slot8", slot(8), (13 << 7) | 8'h7F);
    check("R3 slot4", slot(4), (1 << 7));
    check("R4 slot3 repeat", slot(3), (2 << 7) | 8'h06);
  endtask

  task automatic t_bad_char_id();
    int c0 = wr_count;
    open_xfer();
    send_byte(8'h95); send_byte(8'h33); send_byte(8'h21);
    send_byte(8'hA0); send_byte(8'h01);
    close_xfer();
    check("R11 no write", wr_count - c0, 0);
    check("R11 id recognized after", slot(0), 8'h01);
  endtask

  task automatic t_enable_gate();
    int c0 = wr_count;
    send_bits(8'hB0, 8);
    wait_cyc(10);
    check("R2 enable high no effect", slot(1), (5 << 7) | 8'h44);
    open_xfer(); send_bits(8'hFF, 4); close_xfer();
    open_xfer(); send_byte(8'hA1); send_byte(8'h05); close_xfer();
    check("R2 partial discarded", slot(0), (1 << 7) | 8'h05);
    check("R2 no writes", wr_count - c0, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d0;
    logic [4:0] c0s;
    int c0 = wr_count;
    wr_ready = 1'b0;
    open_xfer();
    send_byte(8'h86); send_byte(8'h0A); send_byte(8'h90); send_byte(8'h77);
    wait_cyc(4);
    d0 = wr_data; c0s = wr_col;
    check("R9 valid while stalled", int'(wr_valid), 1);
    send_byte(8'h78);
    check("R9 data held", int'(wr_data), int'(d0));
    check("R9 col held", int'(wr_col), int'(c0s));
    wr_ready = 1'b1;
    wait_cyc(3);
    send_byte(8'h79);
    close_xfer();
    check("R9 one write then next", wr_count - c0, 2);
    check("R9 stalled write", int'(mem[6*COLS+10]), 8'h77);
    check("R9 dropped word no advance", int'(mem[6*COLS+11]), 8'h79);
  endtask

  task automatic t_fill();
    int c0 = wr_count;
    int bad = 0;
    clear_mem();
    open_xfer();
    send_byte(8'hC4); send_byte(8'h90); send_byte(8'h12);
    close_xfer();
    wait_cyc(300);
    for (int i = 0; i < CELLS; i++) if (mem[i] !== 8'h7F) bad++;
    check("R10 fill count", wr_count - c0, CELLS);
    check("R10 cells not blank", bad, 0);
  endtask

  initial begin
    clear_mem();
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_char_lock();
    t_wrap();
    t_clamp();
    t_release();
    t_cfg();
    t_bad_char_id();
    t_enable_gate();
    t_backpressure();
    t_fill();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule